// File: doc/BRIEF.md
# Serial Converter Result Frame Reader

This block is the host side of a three-wire link to a delta-sigma converter. On a request it pulls the chip select low and waits for the converter's data line to drop, since that line doubles as a busy flag. It then clocks the result in with a host-generated serial clock, most significant bit first. The block samples each bit near the end of the clock's high phase, because the converter moves its data on the falling edge.

A captured frame holds 24 bits. Bit 23 is the end-of-conversion marker, bit 22 the input channel, bit 21 the sign and bit 20 the over-range flag. Bits 19..0 carry the result, with bit 19 as its most significant bit. A read may be cut short to between 4 and 24 bits. The chip select is then raised after the last wanted bit, which ends the output phase and starts the next conversion at once. If the data line stays busy for too long, the read is abandoned and flagged. The result word and its decoded fields stay on the outputs with `data_valid` until the next request.

The controller is one state machine with these states:
- `ST_IDLE`: chip select high, clock low.
- `ST_SETUP`: chip select low, waiting for the setup time.
- `ST_POLL`: watching the data line.
- `ST_SCK_HI` and `ST_SCK_LO`: the two halves of each bit clock.
- `ST_FINISH`: one cycle that raises chip select and loads the outputs.

The transitions are:
- `ST_IDLE` to `ST_SETUP` on `rd_req`.
- `ST_SETUP` to `ST_POLL` after `2*HALF_DIV` cycles.
- `ST_POLL` to `ST_SCK_HI` when the data line is low.
- `ST_POLL` to `ST_FINISH` on timeout.
- `ST_SCK_HI` to `ST_SCK_LO` after `HALF_DIV` cycles.
- `ST_SCK_LO` to `ST_SCK_HI` after `HALF_DIV` cycles while bits remain to be read.
- `ST_SCK_LO` to `ST_FINISH` after `HALF_DIV` cycles once the last bit has been read.
- `ST_FINISH` to `ST_IDLE` always.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset `adc_cs_n` is 1, `adc_sck` is 0 and `data_valid` is 0.
- R2: A `rd_req` in idle drives `adc_cs_n` low. The first rising edge of `adc_sck` comes no sooner than `2*HALF_DIV` clock cycles after `adc_cs_n` falls.
- R3: Clocking starts only after `adc_sdo` is seen low while `adc_cs_n` is low. `adc_sdo` has no effect on any output while `adc_cs_n` is high.
- R4: The effective length is `rd_len` clamped to the range 4..24. Exactly that many rising `adc_sck` edges occur per read. Bits fill `raw_word` from bit 23 downward.
- R5: The decoded outputs are taken from `raw_word` as follows: `eoc_flag` is bit 23, `chan_sel` is bit 22, `sign_bit` is bit 21, `over_range` is bit 20 and `result` is bits 19..0.
- R6: On a read shorter than 24 bits, the unread low bits of `raw_word` are 0 and `truncated` is 1. On a 24-bit read `truncated` is 0.
- R7: `adc_sck` is never high while `adc_cs_n` is high. `adc_cs_n` rises only after `adc_sck` has gone low after the last bit, which restarts conversion.
- R8: Poll cycles are counted from 0. If `adc_sdo` is still high on poll cycle number `eoc_limit`, the read ends with `timeout_err`=1, `raw_word`=0 and `data_valid`=1. Chip select is then low for `2*HALF_DIV + eoc_limit + 1` cycles.
- R9: `data_valid` and all result outputs hold steady until the next accepted `rd_req`. `data_valid` is 0 from the cycle after that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Start a read (taken in idle) |
| rd_len | input | 5 | Requested number of bits |
| eoc_limit | input | 16 | Poll cycle number at which a busy line times out |
| adc_cs_n | output | 1 | Chip select to converter, active low |
| adc_sck | output | 1 | Serial clock to converter |
| adc_sdo | input | 1 | Data / busy line from converter |
| data_valid | output | 1 | Result outputs are valid |
| raw_word | output | 24 | Captured frame |
| eoc_flag | output | 1 | Frame bit 23 |
| chan_sel | output | 1 | Frame bit 22, channel |
| sign_bit | output | 1 | Frame bit 21, sign |
| over_range | output | 1 | Frame bit 20, extended range |
| result | output | 20 | Frame bits 19..0 |
| truncated | output | 1 | Read was shorter than 24 bits |
| timeout_err | output | 1 | Busy line timed out |

## Verification
A wrong bit counter shows up in the same read as a wrong number of serial clock edges, and as result bits shifted or zeroed in the wrong place. A wrong state transition shows up within one bit period, either as a clock pulse while chip select is high or as chip select rising during a high clock phase. A poll counter that is off by one moves the chip-select-low duration of a timed-out read by exactly one cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_BITS = 24;
    localparam int VALUE_BITS = 20;
    localparam int MIN_LEN    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_POLL,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_FINISH
    } rd_state_t;

    typedef struct packed {
        logic                  eoc;
        logic                  chan;
        logic                  sign;
        logic                  ext;
        logic [VALUE_BITS-1:0] value;
    } frame_fields_t;

endpackage

// File: rtl/adc_rd_counter.sv
module adc_rd_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int FRAME_BITS = 24,
    localparam int IW = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  sample,
    input  logic [IW-1:0]         bit_idx,
    input  logic                  sdo,
    output logic [FRAME_BITS-1:0] word
);
    logic [IW-1:0] pos;

    // Bit number k of the frame lands in word position FRAME_BITS-1-k.
    assign pos = IW'(FRAME_BITS - 1) - bit_idx;

    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word[i] <= 1'b0;
            end else if (clr) begin
                word[i] <= 1'b0;
            end else if (sample && (pos == IW'(i))) begin
                word[i] <= sdo;
            end
        end
    end
endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode
    import adc_rd_pkg::*;
(
    input  logic [FRAME_BITS-1:0] raw,
    output frame_fields_t         fields
);
    always_comb begin
        fields = frame_fields_t'(raw);
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int TMO_W    = 16,
    localparam int LEN_W   = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_req,
    input  logic [LEN_W-1:0]      rd_len,
    input  logic [TMO_W-1:0]      eoc_limit,
    output logic                  adc_cs_n,
    output logic                  adc_sck,
    input  logic                  adc_sdo,
    output logic                  data_valid,
    output logic [FRAME_BITS-1:0] raw_word,
    output logic                  eoc_flag,
    output logic                  chan_sel,
    output logic                  sign_bit,
    output logic                  over_range,
    output logic [VALUE_BITS-1:0] result,
    output logic                  truncated,
    output logic                  timeout_err
);
    localparam int SETUP_CYC = 2 * HALF_DIV;
    localparam int HW        = $clog2(SETUP_CYC + 1);

    rd_state_t state, state_nxt;

    logic [HW-1:0]         half_cnt;
    logic [TMO_W-1:0]      poll_cnt;
    logic [LEN_W-1:0]      bit_cnt;
    logic [LEN_W-1:0]      len_q;
    logic [TMO_W-1:0]      limit_q;
    logic                  tmo_hit;
    logic [FRAME_BITS-1:0] shift_word;
    logic [FRAME_BITS-1:0] out_raw;
    frame_fields_t         fields;

    logic accept, phase_end, setup_end, sample, poll_expire, poll_ready;

    assign accept      = (state == ST_IDLE) && rd_req;
    assign phase_end   = (half_cnt == HW'(HALF_DIV - 1));
    assign setup_end   = (half_cnt == HW'(SETUP_CYC - 1));
    assign sample      = (state == ST_SCK_HI) && phase_end;
    assign poll_ready  = (state == ST_POLL) && !adc_sdo;
    assign poll_expire = (state == ST_POLL) && adc_sdo && (poll_cnt == limit_q);

    // Phase timer restarts on every state change.
    adc_rd_counter #(.W(HW)) i_half_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != state_nxt),
        .inc   (1'b1),
        .count (half_cnt)
    );

    adc_rd_counter #(.W(TMO_W)) i_poll_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .inc   (state == ST_POLL),
        .count (poll_cnt)
    );

    adc_rd_counter #(.W(LEN_W)) i_bit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .inc   (sample),
        .count (bit_cnt)
    );

    adc_rd_shifter #(.FRAME_BITS(FRAME_BITS)) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .sample  (sample),
        .bit_idx (bit_cnt),
        .sdo     (adc_sdo),
        .word    (shift_word)
    );

    adc_rd_decode i_decode (
        .raw    (out_raw),
        .fields (fields)
    );

    // Request latch: clamped length and timeout limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= LEN_W'(FRAME_BITS);
            limit_q <= '0;
            tmo_hit <= 1'b0;
        end else begin
            if (accept) begin
                if (rd_len < LEN_W'(MIN_LEN)) begin
                    len_q <= LEN_W'(MIN_LEN);
                end else if (rd_len > LEN_W'(FRAME_BITS)) begin
                    len_q <= LEN_W'(FRAME_BITS);
                end else begin
                    len_q <= rd_len;
                end
                limit_q <= eoc_limit;
                tmo_hit <= 1'b0;
            end else if (poll_expire) begin
                tmo_hit <= 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_req) state_nxt = ST_SETUP;
            end
            ST_SETUP: begin
                if (setup_end) state_nxt = ST_POLL;
            end
            ST_POLL: begin
                if (poll_ready) begin
                    state_nxt = ST_SCK_HI;
                end else if (poll_expire) begin
                    state_nxt = ST_FINISH;
                end
            end
            ST_SCK_HI: begin
                if (phase_end) state_nxt = ST_SCK_LO;
            end
            ST_SCK_LO: begin
                if (phase_end) begin
                    state_nxt = (bit_cnt == len_q) ? ST_FINISH : ST_SCK_HI;
                end
            end
            ST_FINISH: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // Link pins follow the state directly.
    always_comb begin
        adc_cs_n = (state == ST_IDLE) || (state == ST_FINISH);
        adc_sck  = (state == ST_SCK_HI);
    end

    // Result outputs, loaded in ST_FINISH and held until the next request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_valid  <= 1'b0;
            out_raw     <= '0;
            truncated   <= 1'b0;
            timeout_err <= 1'b0;
        end else if (accept) begin
            data_valid <= 1'b0;
        end else if (state == ST_FINISH) begin
            data_valid  <= 1'b1;
            out_raw     <= tmo_hit ? '0 : shift_word;
            truncated   <= !tmo_hit && (len_q < LEN_W'(FRAME_BITS));
            timeout_err <= tmo_hit;
        end
    end

    assign raw_word   = out_raw;
    assign eoc_flag   = fields.eoc;
    assign chan_sel   = fields.chan;
    assign sign_bit   = fields.sign;
    assign over_range = fields.ext;
    assign result     = fields.value;

endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic        adc_cs_n,
    input logic        adc_sck,
    input logic        data_valid,
    input logic [23:0] raw_word,
    input logic        eoc_flag,
    input logic        timeout_err,
    input logic        truncated
);
    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sck |-> !adc_cs_n); // R7

    AST_CS_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_cs_n && !$past(adc_cs_n)) |-> !$past(adc_sck)); // R7

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !rd_req && adc_cs_n) |=> (data_valid && $stable(raw_word))); // R9

    AST_TMO_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && timeout_err) |-> (raw_word == 24'd0 && !truncated)); // R8

    AST_EOC_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !eoc_flag); // R3

    AST_NO_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (adc_cs_n || !adc_sck)); // R7
endmodule

bind adc_frame_reader adc_frame_reader_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .adc_cs_n    (adc_cs_n),
    .adc_sck     (adc_sck),
    .data_valid  (data_valid),
    .raw_word    (raw_word),
    .eoc_flag    (eoc_flag),
    .timeout_err (timeout_err),
    .truncated   (truncated)
);

// File: tb/test_adc_frame_reader.sv
`timescale 1ns/1ps
module test_adc_frame_reader;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [4:0]  rd_len = 5'd24;
    logic [15:0] eoc_limit = 16'd200;
    logic        adc_cs_n, adc_sck, adc_sdo;
    logic        data_valid, eoc_flag, chan_sel, sign_bit, over_range, truncated, timeout_err;
    logic [23:0] raw_word;
    logic [19:0] result;

    always #2.5 clk = ~clk;

    adc_frame_reader #(.HALF_DIV(HALF)) i_adc_frame_reader (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_len(rd_len), .eoc_limit(eoc_limit),
        .adc_cs_n(adc_cs_n), .adc_sck(adc_sck), .adc_sdo(adc_sdo),
        .data_valid(data_valid), .raw_word(raw_word), .eoc_flag(eoc_flag), .chan_sel(chan_sel),
        .sign_bit(sign_bit), .over_range(over_range), .result(result),
        .truncated(truncated), .timeout_err(timeout_err)
    );

    // Converter model
    logic [23:0] m_frame = 24'd0;
    int          m_delay = 0;
    int          conv_cnt = 0;
    int          idx = 0;
    logic        prev_sck = 1'b0;
    logic        junk = 1'b0;

    always @(posedge clk) begin
        junk     <= 1'($urandom);
        prev_sck <= adc_sck;
        if (adc_cs_n) begin
            conv_cnt <= 0;
            idx      <= 0;
        end else begin
            if (conv_cnt < 1000000) conv_cnt <= conv_cnt + 1;
            if (prev_sck && !adc_sck) idx <= idx + 1;
        end
    end

    always_comb begin
        if (adc_cs_n)               adc_sdo = junk;
        else if (conv_cnt < m_delay) adc_sdo = 1'b1;
        else if (idx < 24)          adc_sdo = m_frame[23 - idx];
        else                        adc_sdo = 1'b0;
    end

    // Link monitor
    int   cyc = 0, rise_total = 0, low_total = 0, cs_fall_cyc = 0, first_rise_cyc = 0, bad_sck = 0;
    logic prev_cs = 1'b1, prev_sck_m = 1'b0, wait_rise = 1'b0;

    always @(posedge clk) begin
        cyc        <= cyc + 1;
        prev_cs    <= adc_cs_n;
        prev_sck_m <= adc_sck;
        if (!adc_cs_n) low_total <= low_total + 1;
        if (adc_sck && adc_cs_n) bad_sck <= bad_sck + 1;
        if (adc_sck && !prev_sck_m) begin
            rise_total <= rise_total + 1;
            if (wait_rise) begin
                first_rise_cyc <= cyc;
                wait_rise      <= 1'b0;
            end
        end
        if (prev_cs && !adc_cs_n) begin
            cs_fall_cyc <= cyc;
            wait_rise   <= 1'b1;
        end
    end

    int errors = 0;
    int checks = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_len(input int l);
        if (l < 4)  return 4;
        if (l > 24) return 24;
        return l;
    endfunction

    function automatic logic [23:0] exp_word(input logic [23:0] f, input int l);
        logic [23:0] mask;
        mask = ~((24'd1 << (24 - l)) - 24'd1);
        return f & mask;
    endfunction

    task automatic do_read(input logic [23:0] frame, input int delay, input int len,
                           input int lim, input bit exp_tmo);
        int r0, l0, n, el, guard;
        logic [23:0] ew;
        el = eff_len(len);
        @(negedge clk);
        m_frame   = frame;
        m_delay   = delay;
        rd_len    = 5'(len);
        eoc_limit = 16'(lim);
        r0 = rise_total;
        l0 = low_total;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk("R9 valid cleared after request", 32'(data_valid), 32'd0);
        chk("R2 cs low after request", 32'(adc_cs_n), 32'd0);
        guard = 0;
        while (!data_valid && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk("R9 read completes", 32'(data_valid), 32'd1);
        n  = rise_total - r0;
        ew = exp_tmo ? 24'd0 : exp_word(frame, el);
        chk("R8 timeout flag", 32'(timeout_err), 32'(exp_tmo));
        chk("R4 sck rising edge count", 32'(n), exp_tmo ? 32'd0 : 32'(el));
        chk("R4 raw word", 32'(raw_word), 32'(ew));
        chk("R5 eoc field", 32'(eoc_flag), 32'(ew[23]));
        chk("R5 channel field", 32'(chan_sel), 32'(ew[22]));
        chk("R5 sign field", 32'(sign_bit), 32'(ew[21]));
        chk("R5 range field", 32'(over_range), 32'(ew[20]));
        chk("R5 result field", 32'(result), 32'(ew[19:0]));
        chk("R6 truncated flag", 32'(truncated), (!exp_tmo && el < 24) ? 32'd1 : 32'd0);
        chk("R7 no sck while cs high", 32'(bad_sck), 32'd0);
        if (!exp_tmo) begin
            chk("R2 setup before first sck", 32'((first_rise_cyc - cs_fall_cyc) >= 2*HALF), 32'd1);
        end else begin
            chk("R8 cs low duration", 32'(low_total - l0), 32'(2*HALF + lim + 1));
        end
    endtask

    task automatic hold_check;
        logic [23:0] w;
        w = raw_word;
        repeat (8) @(negedge clk);
        chk("R9 valid held", 32'(data_valid), 32'd1);
        chk("R3 sdo ignored while cs high", 32'(raw_word), 32'(w));
        chk("R7 cs high in idle", 32'(adc_cs_n), 32'd1);
    endtask

    bit wd = 1'b0;

    initial begin
        void'($urandom(32'd12345));
        fork
            begin
                repeat (3) @(negedge clk);
                chk("R1 cs high in reset", 32'(adc_cs_n), 32'd1);
                chk("R1 sck low in reset", 32'(adc_sck), 32'd0);
                chk("R1 valid low in reset", 32'(data_valid), 32'd0);
                rst_n = 1'b1;
                repeat (3) @(negedge clk);
                chk("R1 idle after reset", 32'(adc_cs_n), 32'd1);

                do_read(24'h5ABCDE, 5, 24, 200, 1'b0);   // full frame
                hold_check();
                do_read(24'h7FFFFF, 3, 16, 200, 1'b0);   // short read, ends at bit 8
                hold_check();
                do_read(24'h6A5A5A, 0, 2, 200, 1'b0);    // clamp up to 4
                do_read(24'h123456, 2, 31, 200, 1'b0);   // clamp down to 24
                do_read(24'h0F0F0F, 0, 20, 0, 1'b0);     // ready on first poll, limit 0
                do_read(24'h3CCCCC, 1000, 24, 10, 1'b1); // timeout
                hold_check();
                do_read(24'h2AAAAA, 1000, 8, 0, 1'b1);   // timeout on first poll
                do_read(24'h455555, 20, 24, 200, 1'b0);  // recovery after timeout

                for (int i = 0; i < 40; i++) begin
                    logic [23:0] f;
                    f = {1'b0, 23'($urandom)};
                    do_read(f, int'($urandom % 40), 4 + int'($urandom % 21), 200, 1'b0);
                    if (i % 8 == 0) hold_check();
                end
            end
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule